// File: doc/BRIEF.md
# Configuration Stream Acceptance Guard

This block sits in front of the configuration loader of a programmable device. It watches the word stream that carries a new configuration and decides whether the device may start once loading finishes. A checksum alone cannot catch a well-formed stream that was built for a different device, so the guard also checks three things. It compares the device identifier in the header against its own identifier. It requires a set marker bit at the head of every frame. It requires the stream length to equal the frame count that the header announced.

A stream begins with a synchronisation pattern. Any words before that pattern are skipped. Next comes one header word: the device identifier in bits [31:16] and the frame count in bits [15:0]. The frames follow, each `FRAME_WORDS` words long. The stream ends with one trailer word flagged by `in_last`, which holds the CRC-32 of the header and frame words. On a clean stream the guard raises `start_ok`. On the first problem it latches an error code and refuses start. Both results hold until reset.

Top module: `cfg_stream_guard`

## Requirements
- R1: `in_ready` is 1 in every state except after acceptance or after an error. Once either result is reached, further words have no effect on `start_ok` or `err_code` until reset.
- R2: Words that arrive before the first word equal to `SYNC_PATTERN` are discarded and do not enter the CRC.
- R3: If header bits [31:16] differ from `DEVICE_ID`, then `err_code` becomes 1 and `start_ok` stays 0.
- R4: Bit 31 of the first word of every frame must be 1, and every frame is tested. If that bit is 0, `err_code` becomes 2.
- R5: A trailer (`in_last`=1) that arrives before the announced number of frames is a length error, even when its CRC value is correct. So is a word without `in_last` in the trailer position. In both cases `err_code` becomes 3.
- R6: The CRC is CRC-32 with polynomial 0x04C11DB7, preset to all ones. It is shifted MSB first with no reflection and no final inversion, and it covers the header and frame words only. If the trailer differs from this value, `err_code` becomes 4.
- R7: A stream that passes every check sets `start_ok` to 1 and leaves `err_code` at 0, in the cycle after the trailer is accepted.
- R8: Only the first error is latched, and it holds until reset. `start_ok` is never 1 while `err_code` is non-zero.
- R9: After reset, `in_ready`=1, `start_ok`=0 and `err_code`=0.
- R10: A header frame count of 0 means the trailer directly follows the header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Stream word present |
| in_data | input | 32 | Stream word |
| in_last | input | 1 | Marks the trailer word |
| in_ready | output | 1 | Guard accepts a word this cycle |
| start_ok | output | 1 | Stream accepted; device may start |
| err_code | output | 3 | 0 none, 1 identifier, 2 marker, 3 length, 4 CRC |

## Verification
The assertions assume that the trailer is the only word the source flags with `in_last`. They also assume the source never relies on `in_ready` being high after a result, since words offered then are dropped on purpose. The stimulus follows this: every generated stream flags only its final word. Words pushed after a result exist only to show that they are ignored. Filler words before the sync pattern are drawn at random and adjusted so they never equal the pattern.

// File: rtl/cfg_guard_pkg.sv
package cfg_guard_pkg;

    localparam int          WORD_W    = 32;
    localparam logic [31:0] CRC_POLY  = 32'h04C1_1DB7;
    localparam logic [31:0] CRC_SEED  = 32'hFFFF_FFFF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SYNC,
        ST_HEADER,
        ST_FRAMES,
        ST_TRAILER,
        ST_DONE,
        ST_ERROR
    } guard_state_t;

    typedef enum logic [2:0] {
        ERR_NONE   = 3'd0,
        ERR_DEVICE = 3'd1,
        ERR_MARKER = 3'd2,
        ERR_LENGTH = 3'd3,
        ERR_CRC    = 3'd4
    } guard_err_t;

    typedef struct packed {
        logic [15:0] dev_id;
        logic [15:0] frame_cnt;
    } header_t;

    // One full word through the MSB-first CRC register.
    function automatic logic [31:0] crc32_word(logic [31:0] crc, logic [31:0] word);
        logic [31:0] c;
        logic        fb;
        c = crc;
        for (int i = WORD_W - 1; i >= 0; i--) begin
            fb = c[31] ^ word[i];
            c  = {c[30:0], 1'b0};
            if (fb) c = c ^ CRC_POLY;
        end
        return c;
    endfunction

endpackage

// File: rtl/cfg_guard_crc.sv
module cfg_guard_crc
    import cfg_guard_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              init,
    input  logic              en,
    input  logic [WORD_W-1:0] data,
    output logic [31:0]       crc_q
);
    always_ff @(posedge clk) begin
        if (rst || init) crc_q <= CRC_SEED;
        else if (en)     crc_q <= crc32_word(crc_q, data);
    end

    p_seed_after_init_r6: assert property (@(posedge clk) disable iff (rst)
        init |=> (crc_q == CRC_SEED));

    p_hold_when_idle_r6: assert property (@(posedge clk) disable iff (rst)
        (!init && !en) |=> $stable(crc_q));
endmodule

// File: rtl/cfg_guard_framer.sv
module cfg_guard_framer #(
    parameter int FRAME_WORDS = 8,
    parameter int CNT_W       = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_count,
    input  logic             advance,
    output logic             at_frame_head,
    output logic             on_final_word
);
    localparam int IDX_W = (FRAME_WORDS > 1) ? $clog2(FRAME_WORDS) : 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_WORDS - 1);

    logic [IDX_W-1:0] word_idx;
    logic [CNT_W-1:0] frames_left;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_idx    <= '0;
            frames_left <= '0;
        end else if (load) begin
            word_idx    <= '0;
            frames_left <= load_count;
        end else if (advance) begin
            if (word_idx == IDX_LAST) begin
                word_idx    <= '0;
                frames_left <= frames_left - 1'b1;
            end else begin
                word_idx <= word_idx + 1'b1;
            end
        end
    end

    assign at_frame_head = (word_idx == '0);
    assign on_final_word = (word_idx == IDX_LAST) && (frames_left == CNT_W'(1));

    p_idx_bound_r4: assert property (@(posedge clk) disable iff (rst)
        word_idx <= IDX_LAST);

    p_head_after_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        (advance && !load && word_idx == IDX_LAST) |=> at_frame_head);
endmodule

// File: rtl/cfg_stream_guard.sv
module cfg_stream_guard
    import cfg_guard_pkg::*;
#(
    parameter int          FRAME_WORDS  = 8,
    parameter logic [15:0] DEVICE_ID    = 16'h3A71,
    parameter logic [31:0] SYNC_PATTERN = 32'h5EC7_0A1B
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [31:0] in_data,
    input  logic        in_last,
    output logic        in_ready,
    output logic        start_ok,
    output logic [2:0]  err_code
);
    localparam int CNT_W = 16;

    guard_state_t state_q, state_d;
    guard_err_t   err_q, err_d;
    header_t      hdr;
    logic         take;
    logic         crc_init, crc_en, fr_load, fr_adv;
    logic         at_head, final_word;
    logic [31:0]  crc_q;

    assign hdr  = header_t'(in_data);
    assign take = in_valid && in_ready;

    cfg_guard_crc u_crc (
        .clk   (clk),
        .rst   (rst),
        .init  (crc_init),
        .en    (crc_en),
        .data  (in_data),
        .crc_q (crc_q)
    );

    cfg_guard_framer #(
        .FRAME_WORDS (FRAME_WORDS),
        .CNT_W       (CNT_W)
    ) u_framer (
        .clk           (clk),
        .rst           (rst),
        .load          (fr_load),
        .load_count    (hdr.frame_cnt),
        .advance       (fr_adv),
        .at_frame_head (at_head),
        .on_final_word (final_word)
    );

    always_comb begin
        state_d  = state_q;
        err_d    = err_q;
        crc_init = 1'b0;
        crc_en   = 1'b0;
        fr_load  = 1'b0;
        fr_adv   = 1'b0;
        if (take) begin
            unique case (state_q)
                ST_IDLE, ST_SYNC: begin
                    if (in_data == SYNC_PATTERN) begin
                        state_d  = ST_HEADER;
                        crc_init = 1'b1;
                    end else begin
                        state_d = ST_SYNC;
                    end
                end
                ST_HEADER: begin
                    if (in_last) begin
                        state_d = ST_ERROR;
                        err_d   = ERR_LENGTH;
                    end else if (hdr.dev_id != DEVICE_ID) begin
                        state_d = ST_ERROR;
                        err_d   = ERR_DEVICE;
                    end else begin
                        crc_en  = 1'b1;
                        fr_load = 1'b1;
                        state_d = (hdr.frame_cnt == '0) ? ST_TRAILER : ST_FRAMES;
                    end
                end
                ST_FRAMES: begin
                    if (in_last) begin
                        state_d = ST_ERROR;
                        err_d   = ERR_LENGTH;
                    end else if (at_head && !in_data[31]) begin
                        state_d = ST_ERROR;
                        err_d   = ERR_MARKER;
                    end else begin
                        crc_en = 1'b1;
                        fr_adv = 1'b1;
                        if (final_word) state_d = ST_TRAILER;
                    end
                end
                ST_TRAILER: begin
                    if (!in_last) begin
                        state_d = ST_ERROR;
                        err_d   = ERR_LENGTH;
                    end else if (in_data != crc_q) begin
                        state_d = ST_ERROR;
                        err_d   = ERR_CRC;
                    end else begin
                        state_d = ST_DONE;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            err_q   <= ERR_NONE;
        end else begin
            state_q <= state_d;
            err_q   <= err_d;
        end
    end

    assign in_ready = (state_q != ST_DONE) && (state_q != ST_ERROR);
    assign start_ok = (state_q == ST_DONE);
    assign err_code = err_q;

    p_no_start_on_error_r8: assert property (@(posedge clk) disable iff (rst)
        start_ok |-> (err_code == 3'd0));

    p_error_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (err_code != 3'd0) |=> $stable(err_code));

    p_code_range_r8: assert property (@(posedge clk) disable iff (rst)
        err_code <= 3'd4);

    p_ready_drops_r1: assert property (@(posedge clk) disable iff (rst)
        (start_ok || err_code != 3'd0) |-> !in_ready);

    p_start_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        start_ok |=> start_ok);

    p_crc_only_loading_r2: assert property (@(posedge clk) disable iff (rst)
        crc_en |-> (state_q == ST_HEADER || state_q == ST_FRAMES));
endmodule

// File: tb/cfg_stream_guard_test.sv
module cfg_stream_guard_test;
    localparam int          FW    = 8;
    localparam logic [15:0] DEVID = 16'h3A71;
    localparam logic [31:0] SYNCW = 32'h5EC7_0A1B;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_last = 1'b0;
    logic        in_ready, start_ok;
    logic [2:0]  err_code;

    int n_checks = 0;
    int n_fail   = 0;

    logic [31:0] sw [0:127];
    logic        sl [0:127];
    int          slen;

    always #4 clk = ~clk;

    cfg_stream_guard uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .in_ready(in_ready), .start_ok(start_ok),
        .err_code(err_code)
    );

    function automatic logic [31:0] ref_crc(logic [31:0] c, logic [31:0] d);
        logic [31:0] r = c;
        for (int b = 0; b < 32; b++) begin
            if (r[31] != d[31-b]) r = (r << 1) ^ 32'h04C1_1DB7;
            else                  r = r << 1;
        end
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        in_valid = 1'b0;
        in_last = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic add(input logic [31:0] d, input logic l);
        sw[slen] = d;
        sl[slen] = l;
        slen++;
    endtask

    // sent: frames actually emitted; bad: frame index with cleared marker (-1 none)
    task automatic build(input int garbage, input logic [15:0] id, input int nfr,
                         input int sent, input int bad, input bit extra, input bit corrupt);
        logic [31:0] c, d;
        slen = 0;
        c = 32'hFFFF_FFFF;
        for (int g = 0; g < garbage; g++) begin
            d = $urandom;
            if (d == SYNCW) d = d ^ 32'h1;
            add(d, 1'b0);
        end
        add(SYNCW, 1'b0);
        d = {id, 16'(nfr)};
        add(d, 1'b0);
        c = ref_crc(c, d);
        for (int f = 0; f < sent; f++) begin
            for (int w = 0; w < FW; w++) begin
                d = $urandom;
                if (w == 0) d[31] = (f == bad) ? 1'b0 : 1'b1;
                add(d, 1'b0);
                c = ref_crc(c, d);
            end
        end
        if (extra) begin
            d = $urandom | 32'h8000_0000;
            add(d, 1'b0);
            c = ref_crc(c, d);
        end
        add(corrupt ? (c ^ 32'h0000_0100) : c, 1'b1);
    endtask

    task automatic push(input logic [31:0] d, input logic l);
        in_valid = 1'b1;
        in_data  = d;
        in_last  = l;
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic play();
        for (int i = 0; i < slen; i++) push(sw[i], sl[i]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        int seed_sink;
        seed_sink = $urandom(32'd4711);

        // R9: reset state
        do_reset();
        chk("R9 in_ready", {31'b0, in_ready}, 32'd1);
        chk("R9 start_ok", {31'b0, start_ok}, 32'd0);
        chk("R9 err_code", {29'b0, err_code}, 32'd0);

        // R7, R6, R2: random clean streams with filler before sync
        for (int k = 0; k < 6; k++) begin
            int nf;
            nf = 1 + int'($urandom % 5);
            do_reset();
            build(int'($urandom % 4), DEVID, nf, nf, -1, 1'b0, 1'b0);
            play();
            chk("R7 clean start_ok", {31'b0, start_ok}, 32'd1);
            chk("R7 clean err_code", {29'b0, err_code}, 32'd0);
        end

        // R1: words after acceptance are ignored
        push(32'h0000_0000, 1'b1);
        push(SYNCW, 1'b0);
        chk("R1 start_ok kept", {31'b0, start_ok}, 32'd1);
        chk("R1 err_code kept", {29'b0, err_code}, 32'd0);
        chk("R1 in_ready low", {31'b0, in_ready}, 32'd0);

        // R10: zero frame count
        do_reset();
        build(0, DEVID, 0, 0, -1, 1'b0, 1'b0);
        play();
        chk("R10 zero frames start_ok", {31'b0, start_ok}, 32'd1);

        // R3: wrong identifier, stream otherwise valid
        do_reset();
        build(1, 16'h3A70, 3, 3, -1, 1'b0, 1'b0);
        play();
        chk("R3 err_code", {29'b0, err_code}, 32'd1);
        chk("R3 start_ok", {31'b0, start_ok}, 32'd0);

        // R4: marker cleared in a late frame
        do_reset();
        build(0, DEVID, 4, 4, 3, 1'b0, 1'b0);
        play();
        chk("R4 late frame marker", {29'b0, err_code}, 32'd2);
        do_reset();
        build(0, DEVID, 2, 2, 0, 1'b0, 1'b0);
        play();
        chk("R4 first frame marker", {29'b0, err_code}, 32'd2);

        // R5: early trailer carrying a correct CRC
        do_reset();
        build(0, DEVID, 4, 2, -1, 1'b0, 1'b0);
        play();
        chk("R5 early trailer", {29'b0, err_code}, 32'd3);
        chk("R5 early start_ok", {31'b0, start_ok}, 32'd0);

        // R5: extra word where the trailer belongs
        do_reset();
        build(0, DEVID, 2, 2, -1, 1'b1, 1'b0);
        play();
        chk("R5 overlong stream", {29'b0, err_code}, 32'd3);

        // R6: corrupted trailer
        do_reset();
        build(2, DEVID, 3, 3, -1, 1'b0, 1'b1);
        play();
        chk("R6 crc mismatch", {29'b0, err_code}, 32'd4);
        chk("R6 start_ok", {31'b0, start_ok}, 32'd0);

        // R8: later words cannot change the first latched error
        build(0, 16'h1111, 1, 1, 0, 1'b0, 1'b0);
        play();
        chk("R8 first error held", {29'b0, err_code}, 32'd4);
        chk("R8 in_ready low", {31'b0, in_ready}, 32'd0);

        // R8: identifier error wins even though a marker error follows
        do_reset();
        build(0, 16'hBEEF, 2, 2, 0, 1'b0, 1'b1);
        play();
        chk("R8 first of several", {29'b0, err_code}, 32'd1);

        // R2: a sync value inside frame data after lock has no special meaning
        do_reset();
        slen = 0;
        begin
            logic [31:0] c;
            c = ref_crc(32'hFFFF_FFFF, {DEVID, 16'd1});
            add(32'h1234_5678, 1'b0);
            add(SYNCW, 1'b0);
            add({DEVID, 16'd1}, 1'b0);
            for (int w = 0; w < FW; w++) begin
                logic [31:0] d;
                d = (w == 3) ? SYNCW : ($urandom | 32'h8000_0000);
                add(d, 1'b0);
                c = ref_crc(c, d);
            end
            add(c, 1'b1);
        end
        play();
        chk("R2 sync value as data", {31'b0, start_ok}, 32'd1);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule